// File: doc/BRIEF.md
# SMBus Slave Register Interface

This block is a two-wire SMBus slave that gives a bus master access to a small sensor register file. It oversamples SCL and SDA with the system clock. Each pin passes through a two-flop synchronizer and a three-sample glitch filter. From the cleaned levels the block finds start, repeated start and stop conditions and matches its 7-bit address (0x4C). It then runs the pointer-set, register-write and register-read sequences. It pulls SDA low through an open-drain enable and never drives it high.

The register file sits outside the block and sees a plain synchronous port. Reads and writes use separate address spaces, so the file reports on its own whether the current pointer is valid for each direction. The block also answers the Alert Response Address when the alert source says an alert is pending, and then pulses a service strobe. Packet error checking uses CRC-8 and is optional: a master may append a PEC byte to a write, or clock one extra byte out of a read. A bus-low timeout can be enabled from the register file to return the slave to idle.

Top module: `smb_target`

## Requirements
- R1: After reset the SDA enable is 0 and no write strobe has been issued.
- R2: An address byte is ACKed (SDA pulled low in the ninth clock) only when its upper 7 bits equal 0x4C, or when it equals 0x19 (Alert Response Address 0x0C with R/W=1) while an alert is pending. Any other address is NACKed, and the slave ignores the bus until the next start.
- R3: The first byte after the own address with R/W=0 loads the pointer and is ACKed. The pointer keeps its value across transactions, so a read with no pointer set uses the pointer from the last write transaction.
- R4: In a write, the second byte after the address is write data. If the pointer is a valid write address the byte is ACKed, and one write strobe with (pointer, data) is issued when the next stop or start is seen.
- R5: After ACKing its address with R/W=1, the slave shifts out the register selected by the pointer, MSB first, one bit per SCL clock. The register file has one cycle of read latency. A master NACK releases the bus until the next start.
- R6: If the pointer is not a valid write address, the data byte is NACKed and no write strobe is issued. If the pointer is not a valid read address, the slave leaves SDA released and the master reads 0xFF.
- R7: After the Alert Response Address is ACKed, the slave returns the byte 0x99 (0x4C shifted left, LSB 1) and pulses the alert service output once.
- R8: A third byte in a write is taken as PEC. If CRC-8 (polynomial 0x07, initial value 0) over the address, pointer, data and PEC bytes comes out to 0, the PEC is ACKed and the write stays pending. Otherwise the PEC is NACKed and the pending write is dropped.
- R9: In a read, if the master ACKs the data byte, the next byte is the CRC-8 over the read address byte and the data byte. The CRC restarts at 0 on every start and every repeated start. If the read address is invalid, this byte is 0xFF as well.
- R10: With the timeout enabled, SCL or SDA held low for TO_CYCLES clocks sends the slave to idle with SDA released. With the timeout disabled, the slave keeps its state for as long as the bus is held low.
- R11: SDA enable changes only while SCL is low. A repeated start after the pointer byte produces no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad (wired-AND bus) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| timeout_en_i | input | 1 | Enables the bus-low timeout (control bit from the register file) |
| alert_pending_i | input | 1 | An alert condition is being signalled |
| alert_ack_o | output | 1 | One-cycle pulse once the alert response byte has been sent |
| reg_wr_en_o | output | 1 | One-cycle write strobe |
| reg_wr_addr_o | output | 8 | Write address (the pointer) |
| reg_wr_data_o | output | 8 | Write data |
| reg_wr_ok_i | input | 1 | Pointer is a valid write address |
| reg_rd_en_o | output | 1 | One-cycle read strobe; data is expected one cycle later |
| reg_rd_addr_o | output | 8 | Read address (the pointer) |
| reg_rd_data_i | input | 8 | Read data, valid the cycle after the strobe |
| reg_rd_ok_i | input | 1 | Pointer is a valid read address |

## Verification
A bad bit counter or a wrong protocol state shows up within one byte time. The ACK lands on the wrong SCL clock, or read data is shifted by a bit, and the bench sees it at its very next SDA sample. A corrupted pointer or pending-write flag stays hidden until the transaction ends. It then appears as a missing, extra or misdirected write strobe at the stop, or as a wrong byte on the following read, which the bench compares against its own register model. A wrong CRC accumulator shows in the next PEC byte: a good PEC gets NACKed, a bad PEC gets ACKed, or the extra read byte differs from the value the bench computes.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WR,
    ST_RD,
    ST_RDACK,
    ST_HOLD
  } st_e;

  localparam logic [7:0] CRC_POLY = 8'h07;

  // One byte into a CRC-8, MSB first.
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/smb_pin_filter.sv
module smb_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      pin_o  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&win_q)       pin_o <= 1'b1;
      else if (~|win_q) pin_o <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/smb_timeout.sv
module smb_timeout #(
  parameter int LIMIT = 3750000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic scl_f,
  input  logic sda_f,
  output logic to_evt
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM    = W'(LIMIT);
  localparam logic [W-1:0] LIM_M1 = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic         busy;

  assign busy   = en & (~scl_f | ~sda_f);
  assign to_evt = busy & (cnt_q == LIM_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!busy)         cnt_q <= '0;
    else if (cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/smb_target.sv
module smb_target
  import smb_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR    = 7'h4C,
  parameter logic [6:0] ARA_ADDR    = 7'h0C,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter int         TO_CYCLES   = 3750000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       timeout_en_i,
  input  logic       alert_pending_i,
  output logic       alert_ack_o,
  output logic       reg_wr_en_o,
  output logic [7:0] reg_wr_addr_o,
  output logic [7:0] reg_wr_data_o,
  input  logic       reg_wr_ok_i,
  output logic       reg_rd_en_o,
  output logic [7:0] reg_rd_addr_o,
  input  logic [7:0] reg_rd_data_i,
  input  logic       reg_rd_ok_i
);
  localparam logic [7:0] ARA_RD_BYTE = {ARA_ADDR, 1'b1};
  localparam logic [7:0] ARA_REPLY   = {OWN_ADDR, 1'b1};

  // Pin conditioning, one filter per line.
  logic [1:0] pins_raw, pins_f;
  logic       scl_f, sda_f;
  assign pins_raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_pin
    smb_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .pin_i(pins_raw[g]), .pin_o(pins_f[g])
    );
  end
  assign scl_f = pins_f[1];
  assign sda_f = pins_f[0];

  // Bus events.
  logic start_evt, stop_evt, scl_rise, scl_fall, to_evt;

  smb_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  smb_timeout #(.LIMIT(TO_CYCLES)) u_to (
    .clk(clk), .rst_n(rst_n), .en(timeout_en_i),
    .scl_f(scl_f), .sda_f(sda_f), .to_evt(to_evt)
  );

  // Protocol state.
  st_e        state_q;
  logic [3:0] cnt_q;
  logic [6:0] sh_q;
  logic [1:0] idx_q;
  logic [7:0] ptr_q;
  logic       pend_q;
  logic [7:0] pend_data_q;
  logic [7:0] crc_q;
  logic       ack_val_q, ack_phase_q;
  logic       is_rd_q, is_ara_q;
  logic [7:0] tx_sh_q;
  logic       tx_drv_q;
  logic       rd_load_q;
  logic       m_ack_q;
  logic       sda_oe_q, wr_en_q, rd_en_q, ara_ack_q;

  logic [7:0] rx_byte;
  logic       addr_hit, ara_hit, byte_done, st_idle;
  logic [1:0] idx_nx;

  assign rx_byte   = {sh_q, sda_f};
  assign addr_hit  = (rx_byte[7:1] == OWN_ADDR);
  assign ara_hit   = (rx_byte == ARA_RD_BYTE) & alert_pending_i;
  assign byte_done = scl_rise & (cnt_q == 4'd7);
  assign idx_nx    = (idx_q == 2'd3) ? idx_q : idx_q + 2'd1;
  assign st_idle   = (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      idx_q       <= '0;
      ptr_q       <= '0;
      pend_q      <= 1'b0;
      pend_data_q <= '0;
      crc_q       <= '0;
      ack_val_q   <= 1'b0;
      ack_phase_q <= 1'b0;
      is_rd_q     <= 1'b0;
      is_ara_q    <= 1'b0;
      tx_sh_q     <= '1;
      tx_drv_q    <= 1'b0;
      rd_load_q   <= 1'b0;
      m_ack_q     <= 1'b0;
      sda_oe_q    <= 1'b0;
      wr_en_q     <= 1'b0;
      rd_en_q     <= 1'b0;
      ara_ack_q   <= 1'b0;
    end else begin
      wr_en_q   <= 1'b0;
      rd_en_q   <= 1'b0;
      ara_ack_q <= 1'b0;
      rd_load_q <= rd_en_q;

      // One cycle after the read strobe the register file data is valid.
      if (rd_load_q) begin
        tx_sh_q <= reg_rd_data_i;
        crc_q   <= crc8_step(crc_q, reg_rd_data_i);
      end

      if (to_evt) begin
        state_q   <= ST_IDLE;
        sda_oe_q  <= 1'b0;
        pend_q    <= 1'b0;
        rd_load_q <= 1'b0;
      end else if (start_evt || stop_evt) begin
        if (pend_q) wr_en_q <= 1'b1;
        pend_q      <= 1'b0;
        sda_oe_q    <= 1'b0;
        cnt_q       <= '0;
        idx_q       <= '0;
        crc_q       <= '0;
        ack_phase_q <= 1'b0;
        rd_load_q   <= 1'b0;
        state_q     <= start_evt ? ST_ADDR : ST_IDLE;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise) begin
              sh_q  <= rx_byte[6:0];
              cnt_q <= cnt_q + 4'd1;
            end
            if (byte_done) begin
              if (addr_hit) begin
                crc_q     <= crc8_step(crc_q, rx_byte);
                is_rd_q   <= rx_byte[0];
                is_ara_q  <= 1'b0;
                ack_val_q <= 1'b1;
                state_q   <= ST_ACK;
                if (rx_byte[0]) begin
                  rd_en_q  <= 1'b1;
                  tx_drv_q <= reg_rd_ok_i;
                end
              end else if (ara_hit) begin
                crc_q     <= crc8_step(crc8_step(crc_q, rx_byte), ARA_REPLY);
                is_rd_q   <= 1'b1;
                is_ara_q  <= 1'b1;
                ack_val_q <= 1'b1;
                tx_sh_q   <= ARA_REPLY;
                tx_drv_q  <= 1'b1;
                state_q   <= ST_ACK;
              end else begin
                state_q <= ST_HOLD;
              end
            end
          end

          ST_ACK: begin
            if (scl_fall) begin
              if (!ack_phase_q) begin
                ack_phase_q <= 1'b1;
                sda_oe_q    <= ack_val_q;
              end else begin
                ack_phase_q <= 1'b0;
                cnt_q       <= '0;
                if (!ack_val_q) begin
                  state_q  <= ST_HOLD;
                  sda_oe_q <= 1'b0;
                end else if (is_rd_q) begin
                  state_q  <= ST_RD;
                  sda_oe_q <= tx_drv_q & ~tx_sh_q[7];
                end else begin
                  state_q  <= ST_WR;
                  sda_oe_q <= 1'b0;
                end
              end
            end
          end

          ST_WR: begin
            if (scl_rise) begin
              sh_q  <= rx_byte[6:0];
              cnt_q <= cnt_q + 4'd1;
            end
            if (byte_done) begin
              crc_q   <= crc8_step(crc_q, rx_byte);
              idx_q   <= idx_nx;
              state_q <= ST_ACK;
              unique case (idx_q)
                2'd0: begin
                  ptr_q     <= rx_byte;
                  ack_val_q <= 1'b1;
                end
                2'd1: begin
                  ack_val_q <= reg_wr_ok_i;
                  if (reg_wr_ok_i) begin
                    pend_q      <= 1'b1;
                    pend_data_q <= rx_byte;
                  end
                end
                2'd2: begin
                  if (crc8_step(crc_q, rx_byte) == 8'h00) begin
                    ack_val_q <= 1'b1;
                  end else begin
                    ack_val_q <= 1'b0;
                    pend_q    <= 1'b0;
                  end
                end
                default: ack_val_q <= 1'b0;
              endcase
            end
          end

          ST_RD: begin
            if (scl_rise) cnt_q <= cnt_q + 4'd1;
            if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_RDACK;
              end else begin
                tx_sh_q  <= tx_sh_q << 1;
                sda_oe_q <= tx_drv_q & ~tx_sh_q[6];
              end
            end
          end

          ST_RDACK: begin
            if (scl_rise) begin
              m_ack_q <= ~sda_f;
              if (is_ara_q && idx_q == 2'd0) ara_ack_q <= 1'b1;
            end
            if (scl_fall) begin
              cnt_q <= '0;
              if (m_ack_q) begin
                idx_q   <= idx_nx;
                state_q <= ST_RD;
                if (idx_q == 2'd0) begin
                  tx_sh_q  <= crc_q;
                  sda_oe_q <= tx_drv_q & ~crc_q[7];
                end else begin
                  tx_sh_q  <= 8'hFF;
                  tx_drv_q <= 1'b0;
                  sda_oe_q <= 1'b0;
                end
              end else begin
                state_q <= ST_HOLD;
              end
            end
          end

          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o      = sda_oe_q;
  assign alert_ack_o   = ara_ack_q;
  assign reg_wr_en_o   = wr_en_q;
  assign reg_wr_addr_o = ptr_q;
  assign reg_wr_data_o = pend_data_q;
  assign reg_rd_en_o   = rd_en_q;
  assign reg_rd_addr_o = ptr_q;
endmodule

// File: rtl/smb_target_chk.sv
module smb_target_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_hi,
  input logic start_evt,
  input logic stop_evt,
  input logic to_evt,
  input logic wr_en,
  input logic rd_en,
  input logic ara_ack,
  input logic in_idle
);
  // R1: an idle slave never pulls SDA
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  // R4: writes are issued only on a bus condition, one cycle wide
  p_wr_on_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(start_evt || stop_evt));
  p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R5: one read strobe per read
  p_rd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  // R7: alert service is a single pulse
  p_ara_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ara_ack |=> !ara_ack);

  // R10: a timeout leaves the slave idle with SDA released
  p_timeout_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    to_evt |=> (in_idle && !sda_oe));

  // R11: the SDA enable holds while SCL is high, barring bus conditions
  p_oe_scl_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hi && !start_evt && !stop_evt && !to_evt) |=> $stable(sda_oe));
endmodule

bind smb_target smb_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_hi(scl_f),
  .start_evt(start_evt), .stop_evt(stop_evt), .to_evt(to_evt),
  .wr_en(reg_wr_en_o), .rd_en(reg_rd_en_o), .ara_ack(alert_ack_o),
  .in_idle(st_idle)
);

// File: tb/smb_target_bench.sv
module smb_target_bench;
  localparam int H  = 16;
  localparam int TO = 1000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, to_en = 1'b0, alert_pend = 1'b0, alert_ack;
  logic wr_en, rd_en, wr_ok, rd_ok;
  logic [7:0] wr_addr, wr_data, rd_addr, rdq;
  wire sda_bus = m_sda & ~sda_oe;

  int vec = 0, bad = 0, wr_cnt = 0, ara_cnt = 0;
  logic [7:0] last_wa = 8'h00, last_wd = 8'h00;
  logic [7:0] rf [0:15];

  function automatic logic wr_valid(input logic [7:0] a);
    return (a >= 8'h09) && (a <= 8'h0F);
  endfunction
  function automatic logic rd_valid(input logic [7:0] a);
    return a <= 8'h09;
  endfunction
  // Reference CRC-8 (poly 0x107) by long division of a 16-bit dividend.
  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
    logic [15:0] v;
    v = {c ^ b, 8'h00};
    for (int i = 15; i >= 8; i--) if (v[i]) v = v ^ (16'h0107 << (i - 8));
    return v[7:0];
  endfunction

  assign wr_ok = wr_valid(wr_addr);
  assign rd_ok = rd_valid(rd_addr);

  smb_target #(.TO_CYCLES(TO)) u_smb_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .timeout_en_i(to_en), .alert_pending_i(alert_pend), .alert_ack_o(alert_ack),
    .reg_wr_en_o(wr_en), .reg_wr_addr_o(wr_addr), .reg_wr_data_o(wr_data),
    .reg_wr_ok_i(wr_ok), .reg_rd_en_o(rd_en), .reg_rd_addr_o(rd_addr),
    .reg_rd_data_i(rdq), .reg_rd_ok_i(rd_ok)
  );

  // Register file model: write address w lands in read slot w-6.
  initial for (int i = 0; i < 16; i++) rf[i] = 8'(i * 37 + 5);
  always @(posedge clk) begin
    if (wr_en) begin
      wr_cnt++;
      last_wa = wr_addr;
      last_wd = wr_data;
      rf[4'(wr_addr - 8'd6)] = wr_data;
    end
    if (rd_en) rdq <= rf[rd_addr[3:0]];
    if (alert_ack) ara_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; hw(H);
    m_sda = 1'b0; hw(H);
    m_scl = 1'b0;
  endtask
  task automatic bus_rstart();
    m_sda = 1'b1; hw(H);
    m_scl = 1'b1; hw(H);
    m_sda = 1'b0; hw(H);
    m_scl = 1'b0;
  endtask
  task automatic bus_stop();
    m_sda = 1'b0; hw(H);
    m_scl = 1'b1; hw(H);
    m_sda = 1'b1; hw(H);
  endtask
  task automatic send_bits8(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hw(H);
      m_scl = 1'b1; hw(H);
      m_scl = 1'b0;
    end
    m_sda = 1'b1;
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits8(b);
    hw(H);
    m_scl = 1'b1; hw(H / 2);
    ack = ~sda_bus; hw(H / 2);
    m_scl = 1'b0;
  endtask
  task automatic recv_byte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(H);
      m_scl = 1'b1; hw(H / 2);
      b[i] = sda_bus; hw(H / 2);
      m_scl = 1'b0;
    end
    m_sda = ~mack; hw(H);
    m_scl = 1'b1; hw(H);
    m_scl = 1'b0;
    m_sda = 1'b1;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] d, p, expd;
    int wc;
    hw(5);
    rst_n = 1'b1;
    hw(10);
    // R1: reset state
    check("R1 sda_oe after reset", sda_oe, 0);
    check("R1 no write after reset", wr_cnt, 0);

    // R2: address sweep over all 7-bit addresses with R/W=0
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      bus_stop();
      check($sformatf("R2 ack for addr %0h", a), ack, (a == 8'h4C));
    end
    check("R2 no write from address-only frames", wr_cnt, 0);

    // R3/R4/R6: write sweep over pointers, then pointer-retained read
    for (int w = 5; w <= 18; w++) begin
      wc = wr_cnt;
      d  = 8'(w) ^ 8'hA5;
      bus_start();
      send_byte(8'h98, ack);
      send_byte(8'(w), ack);
      check($sformatf("R3 pointer ack %0h", w), ack, 1);
      send_byte(d, ack);
      check($sformatf("R4 R6 data ack %0h", w), ack, wr_valid(8'(w)));
      bus_stop();
      hw(4);
      check($sformatf("R4 R6 write count %0h", w), wr_cnt, wc + int'(wr_valid(8'(w))));
      if (wr_valid(8'(w))) begin
        check($sformatf("R4 write addr %0h", w), last_wa, w);
        check($sformatf("R4 write data %0h", w), last_wd, d);
      end
      // R3: no pointer set, read uses retained pointer
      expd = rd_valid(8'(w)) ? rf[w[3:0]] : 8'hFF;
      bus_start();
      send_byte(8'h99, ack);
      recv_byte(1'b0, d);
      bus_stop();
      check($sformatf("R3 R6 retained-pointer read %0h", w), d, expd);
    end

    // R5/R9/R11: pointer set, repeated start, read data plus PEC
    for (int r = 0; r <= 11; r++) begin
      wc = wr_cnt;
      bus_start();
      send_byte(8'h98, ack);
      send_byte(8'(r), ack);
      bus_rstart();
      send_byte(8'h99, ack);
      check($sformatf("R5 read addr ack %0h", r), ack, 1);
      recv_byte(1'b1, d);
      recv_byte(1'b0, p);
      bus_stop();
      hw(4);
      expd = rd_valid(8'(r)) ? rf[r[3:0]] : 8'hFF;
      check($sformatf("R5 R6 read data %0h", r), d, expd);
      check($sformatf("R9 read pec %0h", r), p,
            rd_valid(8'(r)) ? ref_crc(ref_crc(8'h00, 8'h99), expd) : 8'hFF);
      check($sformatf("R11 no write on repeated start %0h", r), wr_cnt, wc);
    end

    // R8: write with good and bad PEC
    for (int k = 0; k < 4; k++) begin
      logic [7:0] w;
      w = 8'(9 + k);
      d = 8'(8'h3C + k * 17);
      p = ref_crc(ref_crc(ref_crc(8'h00, 8'h98), w), d);
      wc = wr_cnt;
      bus_start();
      send_byte(8'h98, ack); send_byte(w, ack); send_byte(d, ack);
      send_byte(p, ack);
      bus_stop();
      hw(4);
      check($sformatf("R8 good pec ack %0d", k), ack, 1);
      check($sformatf("R8 good pec write %0d", k), wr_cnt, wc + 1);
      check($sformatf("R8 good pec data %0d", k), last_wd, d);
      wc = wr_cnt;
      bus_start();
      send_byte(8'h98, ack); send_byte(w, ack); send_byte(d ^ 8'h0F, ack);
      send_byte(p ^ 8'h80, ack);
      bus_stop();
      hw(4);
      check($sformatf("R8 bad pec nack %0d", k), ack, 0);
      check($sformatf("R8 bad pec no write %0d", k), wr_cnt, wc);
    end

    // R7: alert response address
    alert_pend = 1'b1;
    wc = ara_cnt;
    bus_start();
    send_byte(8'h19, ack);
    check("R7 ARA ack", ack, 1);
    recv_byte(1'b1, d);
    recv_byte(1'b0, p);
    bus_stop();
    check("R7 ARA reply", d, 8'h99);
    check("R9 ARA pec", p, ref_crc(ref_crc(8'h00, 8'h19), 8'h99));
    check("R7 ARA service pulse", ara_cnt, wc + 1);
    alert_pend = 1'b0;
    bus_start();
    send_byte(8'h19, ack);
    bus_stop();
    check("R2 R7 ARA nack without alert", ack, 0);

    // R10: timeout disabled, slave keeps driving its ACK
    to_en = 1'b0;
    bus_start();
    send_bits8(8'h98);
    hw(TO + 500);
    check("R10 no timeout when disabled", sda_oe, 1);
    m_scl = 1'b1; hw(H); m_scl = 1'b0; hw(H);
    bus_stop();
    // R10: timeout enabled, slave returns to idle
    to_en = 1'b1;
    bus_start();
    send_bits8(8'h98);
    hw(H);
    check("R10 ack driven before timeout", sda_oe, 1);
    hw(TO + 500);
    check("R10 released after timeout", sda_oe, 0);
    bus_stop();
    bus_start();
    send_byte(8'h98, ack);
    bus_stop();
    check("R10 recovers after timeout", ack, 1);
    to_en = 1'b0;

    hw(20);
    finish_run();
  end
endmodule